// File: doc/BRIEF.md
# Line Deduplication Checker

This block sits in the write path of a memory controller for non-volatile main memory and decides whether the 512-bit line that is about to be written is already stored somewhere in memory. For each write it accepts, it forms a CRC-32 fingerprint of the whole line. It then looks that fingerprint up in a small direct-mapped table. Each table entry holds a full fingerprint, a stored line address and a valid flag.

A fingerprint match alone is never trusted. When the fingerprint matches, the block fetches the candidate line through a read port and compares it with the incoming line one byte per cycle. The comparison stops at the first byte that differs.

The block reports exactly one result per accepted write:
- A duplicate, together with the address that already holds the data. In this case the memory write of the incoming line is cancelled.
- A non-duplicate. In this case the write goes ahead and the table entry is overwritten with the new fingerprint and address.

Only one write is handled at a time. The requester waits for `req_ready` before presenting the next line.

Top module: `line_dedup_chk`

## Requirements
- R1: After reset, `req_ready` is 1 while `res_valid` and `rd_req` are 0.
- R2: With every result, `res_fp` carries the CRC-32 of the line. The CRC uses the reflected polynomial 0xEDB88320, a starting value of all ones and a final inversion. Bytes are fed in the order 0 to 63, where byte i is `req_line[8i+7:8i]`. Each byte is fed least significant bit first, and one 64-bit word is consumed per cycle.
- R3: The table index is `res_fp[5:0]`. If the entry at that index is invalid, or holds a different fingerprint, the result is non-duplicate with `res_wr_en`=1. No `rd_req` is issued, and the entry takes the new fingerprint and `req_addr`.
- R4: If the entry holds the same fingerprint, exactly one `rd_req` is issued before the result, and `rd_addr` is set to the stored address.
- R5: If all 64 bytes returned on `rd_line` equal the incoming line, the result is a duplicate. The block sets `res_dup`=1, sets `res_addr` to the stored address, and sets `res_wr_en`=0, which cancels the write.
- R6: If any byte differs, the result is non-duplicate with `res_wr_en`=1. The entry is replaced with the new fingerprint and address, so a later copy of the same line is matched against the new address.
- R7: The comparison ends at the first differing byte. The delay from read data to result grows by exactly k cycles when the first mismatch is at byte k instead of byte 0. A full match takes as long as a mismatch at byte 63.
- R8: A duplicate result leaves the table unchanged, so further copies keep matching the original address.
- R9: `req_ready` goes low in the cycle after a request is accepted and stays low until the cycle in which `res_valid` pulses for one cycle. No `rd_req` is issued while `req_ready` is 1.
- R10: A line whose fingerprint has the same index as a stored one, but differs from it, evicts that entry. A later copy of the evicted line is then reported as a non-duplicate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write line offered |
| req_ready | output | 1 | Block idle, request accepted when both are high |
| req_addr | input | 32 | Target address of the incoming line |
| req_line | input | 512 | Incoming line data |
| rd_req | output | 1 | One-cycle read request for a candidate line |
| rd_addr | output | 32 | Address of the candidate line |
| rd_valid | input | 1 | Read data returned |
| rd_line | input | 512 | Returned candidate line |
| res_valid | output | 1 | One-cycle result strobe |
| res_dup | output | 1 | Line already stored |
| res_wr_en | output | 1 | Memory write must go ahead (0 cancels it) |
| res_addr | output | 32 | Matching address for a duplicate, otherwise the request address |
| res_fp | output | 32 | CRC-32 fingerprint of the line |

## Verification
The assertions check the handshake on every cycle:
- `req_ready` stays low while a request is in flight, and no read is issued while the block is idle.
- At most one read is issued per request.
- `res_valid` is a single-cycle pulse.
- A duplicate is only ever reported after a read, and it names the same address that was read.

Some behaviour can only be shown by the bench's scenarios. These are the fingerprint value, the table filling and eviction, the replacement after a mismatch, the persistence after a duplicate, and the exact latency relation of the early-exit comparison. The bench drives these with a memory model that it corrupts on purpose.

// File: rtl/dedup_pkg.sv
package dedup_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HASH,
    ST_LOOK,
    ST_CHECK,
    ST_WAIT,
    ST_CMP
  } dd_state_t;
endpackage

// File: rtl/dedup_crc_engine.sv
module dedup_crc_engine #(
  parameter int LINE_W = 512,
  parameter int WORD_W = 64,
  parameter int CRC_W  = 32,
  parameter logic [CRC_W-1:0] POLY = 32'hEDB88320
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LINE_W-1:0] line,
  output logic              done,
  output logic [CRC_W-1:0]  crc
);
  localparam int NW     = LINE_W / WORD_W;
  localparam int WIDX_W = (NW > 1) ? $clog2(NW) : 1;

  logic              busy_q;
  logic [WIDX_W-1:0] widx_q;
  logic [CRC_W-1:0]  acc_q;
  logic [CRC_W-1:0]  acc_nx;
  logic [WORD_W-1:0] word;

  assign word = line[widx_q*WORD_W +: WORD_W];

  always_comb begin
    logic [CRC_W-1:0] c;
    c = acc_q;
    for (int i = 0; i < WORD_W; i++) begin
      if (c[0] ^ word[i]) c = (c >> 1) ^ POLY;
      else                c = c >> 1;
    end
    acc_nx = c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      widx_q <= '0;
      acc_q  <= '1;
      done   <= 1'b0;
      crc    <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        widx_q <= '0;
        acc_q  <= '1;
      end else if (busy_q) begin
        acc_q <= acc_nx;
        if (widx_q == WIDX_W'(NW - 1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
          crc    <= ~acc_nx;
        end else begin
          widx_q <= widx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dedup_fp_table.sv
module dedup_fp_table #(
  parameter int IDX_W  = 6,
  parameter int CRC_W  = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_vld,
  output logic [CRC_W-1:0]  rd_tag,
  output logic [ADDR_W-1:0] rd_adr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [CRC_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_adr
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int ENT_W = CRC_W + ADDR_W;

  logic [ENT_W-1:0] ram [DEPTH];
  logic [ENT_W-1:0] ram_q;
  logic [DEPTH-1:0] vld_vec;

  // Entry storage: plain synchronous RAM, no reset, registered read.
  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_idx] <= {wr_tag, wr_adr};
    if (rd_en) ram_q <= ram[rd_idx];
  end

  // Valid flags live in flops so reset can clear them.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_vec <= '0;
      rd_vld  <= 1'b0;
    end else begin
      if (wr_en) vld_vec[wr_idx] <= 1'b1;
      if (rd_en) rd_vld <= vld_vec[rd_idx];
    end
  end

  assign rd_tag = ram_q[ENT_W-1 -: CRC_W];
  assign rd_adr = ram_q[ADDR_W-1:0];
endmodule

// File: rtl/dedup_byte_cmp.sv
module dedup_byte_cmp #(
  parameter int LINE_W = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LINE_W-1:0] a,
  input  logic [LINE_W-1:0] b,
  output logic              done,
  output logic              equal
);
  localparam int NB     = LINE_W / 8;
  localparam int BIDX_W = (NB > 1) ? $clog2(NB) : 1;

  logic              busy_q;
  logic [BIDX_W-1:0] bidx_q;
  logic              same;

  assign same = (a[bidx_q*8 +: 8] == b[bidx_q*8 +: 8]);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      bidx_q <= '0;
      done   <= 1'b0;
      equal  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        bidx_q <= '0;
      end else if (busy_q) begin
        if (!same) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
          equal  <= 1'b0;
        end else if (bidx_q == BIDX_W'(NB - 1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
          equal  <= 1'b1;
        end else begin
          bidx_q <= bidx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/line_dedup_chk.sv
module line_dedup_chk #(
  parameter int LINE_W = 512,
  parameter int WORD_W = 64,
  parameter int ADDR_W = 32,
  parameter int CRC_W  = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LINE_W-1:0] req_line,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [LINE_W-1:0] rd_line,
  output logic              res_valid,
  output logic              res_dup,
  output logic              res_wr_en,
  output logic [ADDR_W-1:0] res_addr,
  output logic [CRC_W-1:0]  res_fp
);
  import dedup_pkg::*;

  dd_state_t         st_q;
  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] cand_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CRC_W-1:0]  fp_q;

  logic              crc_start, crc_done;
  logic [CRC_W-1:0]  crc_val;
  logic              cmp_start, cmp_done, cmp_eq;
  logic              tb_rd_en, tb_vld, tb_wr_en;
  logic [CRC_W-1:0]  tb_tag;
  logic [ADDR_W-1:0] tb_adr;
  logic              hit;

  dedup_crc_engine #(.LINE_W(LINE_W), .WORD_W(WORD_W), .CRC_W(CRC_W)) u_crc (
    .clk(clk), .rst(rst), .start(crc_start), .line(line_q),
    .done(crc_done), .crc(crc_val)
  );

  dedup_fp_table #(.IDX_W(IDX_W), .CRC_W(CRC_W), .ADDR_W(ADDR_W)) u_tbl (
    .clk(clk), .rst(rst),
    .rd_en(tb_rd_en), .rd_idx(fp_q[IDX_W-1:0]),
    .rd_vld(tb_vld), .rd_tag(tb_tag), .rd_adr(tb_adr),
    .wr_en(tb_wr_en), .wr_idx(fp_q[IDX_W-1:0]),
    .wr_tag(fp_q), .wr_adr(addr_q)
  );

  dedup_byte_cmp #(.LINE_W(LINE_W)) u_cmp (
    .clk(clk), .rst(rst), .start(cmp_start),
    .a(line_q), .b(cand_q), .done(cmp_done), .equal(cmp_eq)
  );

  assign req_ready = (st_q == ST_IDLE);
  assign hit       = tb_vld && (tb_tag == fp_q);
  assign tb_rd_en  = (st_q == ST_LOOK);
  assign tb_wr_en  = ((st_q == ST_CHECK) && !hit) ||
                     ((st_q == ST_CMP) && cmp_done && !cmp_eq);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      line_q    <= '0;
      cand_q    <= '0;
      addr_q    <= '0;
      fp_q      <= '0;
      crc_start <= 1'b0;
      cmp_start <= 1'b0;
      rd_req    <= 1'b0;
      rd_addr   <= '0;
      res_valid <= 1'b0;
      res_dup   <= 1'b0;
      res_wr_en <= 1'b0;
      res_addr  <= '0;
      res_fp    <= '0;
    end else begin
      crc_start <= 1'b0;
      cmp_start <= 1'b0;
      rd_req    <= 1'b0;
      res_valid <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            line_q    <= req_line;
            addr_q    <= req_addr;
            crc_start <= 1'b1;
            st_q      <= ST_HASH;
          end
        end
        ST_HASH: begin
          if (crc_done) begin
            fp_q <= crc_val;
            st_q <= ST_LOOK;
          end
        end
        ST_LOOK: st_q <= ST_CHECK;
        ST_CHECK: begin
          if (hit) begin
            rd_req  <= 1'b1;
            rd_addr <= tb_adr;
            st_q    <= ST_WAIT;
          end else begin
            res_valid <= 1'b1;
            res_dup   <= 1'b0;
            res_wr_en <= 1'b1;
            res_addr  <= addr_q;
            res_fp    <= fp_q;
            st_q      <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (rd_valid) begin
            cand_q    <= rd_line;
            cmp_start <= 1'b1;
            st_q      <= ST_CMP;
          end
        end
        ST_CMP: begin
          if (cmp_done) begin
            res_valid <= 1'b1;
            res_dup   <= cmp_eq;
            res_wr_en <= !cmp_eq;
            res_addr  <= cmp_eq ? rd_addr : addr_q;
            res_fp    <= fp_q;
            st_q      <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dedup_chk.sv
module dedup_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              res_valid,
  input logic              res_dup,
  input logic [ADDR_W-1:0] res_addr
);
  logic              saw_rd;
  logic [ADDR_W-1:0] seen_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      saw_rd    <= 1'b0;
      seen_addr <= '0;
    end else if (req_valid && req_ready) begin
      saw_rd <= 1'b0;
    end else if (rd_req) begin
      saw_rd    <= 1'b1;
      seen_addr <= rd_addr;
    end
  end

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  no_idle_read_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !rd_req);

  // R9
  result_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R4
  single_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !saw_rd);

  // R5
  dup_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_dup) |-> (saw_rd && res_addr == seen_addr));
endmodule

bind line_dedup_chk dedup_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rd_req(rd_req), .rd_addr(rd_addr), .res_valid(res_valid),
  .res_dup(res_dup), .res_addr(res_addr)
);

// File: tb/sim_line_dedup_chk.sv
`timescale 1ns/1ps
module sim_line_dedup_chk;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [31:0]  req_addr = '0;
  logic [511:0] req_line = '0;
  logic         rd_req;
  logic [31:0]  rd_addr;
  logic         rd_valid = 1'b0;
  logic [511:0] rd_line = '0;
  logic         res_valid, res_dup, res_wr_en;
  logic [31:0]  res_addr, res_fp;

  always #5 clk = ~clk;

  line_dedup_chk u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_line(req_line), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_line(rd_line),
    .res_valid(res_valid), .res_dup(res_dup), .res_wr_en(res_wr_en),
    .res_addr(res_addr), .res_fp(res_fp)
  );

  // Memory model behind the read port, two-cycle latency.
  logic [511:0] mem [16];
  logic         pend = 1'b0;
  logic [31:0]  padr = '0;
  always @(posedge clk) begin
    rd_valid <= 1'b0;
    if (rd_req) begin
      pend <= 1'b1;
      padr <= rd_addr;
    end
    if (pend) begin
      rd_valid <= 1'b1;
      rd_line  <= mem[padr[3:0]];
      pend     <= 1'b0;
    end
  end

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (!finished && cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [511:0] d);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < 512; i++) begin
      logic fb = c[0] ^ d[i];
      c = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    return ~c;
  endfunction

  // Independent model of the fingerprint table.
  bit          m_vld [64];
  logic [31:0] m_tag [64];
  logic [31:0] m_adr [64];

  int o_lat, o_rds;
  logic o_dup, o_wr;
  logic [31:0] o_addr, o_fp;

  task automatic issue(input logic [31:0] a, input logic [511:0] d);
    int lat = 0;
    bit seen = 1'b0;
    @(negedge clk);
    req_addr  = a;
    req_line  = d;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    o_rds = 0;
    forever begin
      if (seen) lat++;
      if (rd_valid) seen = 1'b1;
      if (rd_req) o_rds++;
      if (res_valid) break;
      @(negedge clk);
    end
    o_lat = lat; o_dup = res_dup; o_wr = res_wr_en;
    o_addr = res_addr; o_fp = res_fp;
    if (res_wr_en) mem[a[3:0]] = d;
  endtask

  // Send a line and compare every output against the model.
  task automatic run_line(input string req, input logic [31:0] a, input logic [511:0] d);
    logic [31:0] fp = ref_crc(d);
    int ix = fp[5:0];
    bit hit = m_vld[ix] && (m_tag[ix] == fp);
    bit dup = hit && (mem[m_adr[ix][3:0]] == d);
    logic [31:0] ea = dup ? m_adr[ix] : a;
    issue(a, d);
    chk({req, " R2 fp"}, o_fp, fp);
    chk({req, " dup"}, o_dup, dup);
    chk({req, " wr_en"}, o_wr, !dup);
    chk({req, " addr"}, o_addr, ea);
    chk({req, " R4 reads"}, o_rds, hit ? 1 : 0);
    if (!dup) begin
      m_vld[ix] = 1'b1; m_tag[ix] = fp; m_adr[ix] = a;
    end
  endtask

  logic [511:0] line_a;

  task automatic t_reset();
    chk("R1 ready", req_ready, 1);
    chk("R1 res_valid", res_valid, 0);
    chk("R1 rd_req", rd_req, 0);
  endtask

  task automatic t_fresh();
    line_a = {16{32'hC0DE1234}} ^ 512'h1;
    run_line("R3 first", 32'd1, line_a);
    chk("R3 nondup", o_dup, 0);
    chk("R9 ready after result", req_ready, 1);
  endtask

  task automatic t_dup();
    run_line("R5 dup", 32'd2, line_a);
    chk("R5 match addr", o_addr, 32'd1);
    chk("R5 cancel", o_wr, 0);
    run_line("R8 keep", 32'd3, line_a);
    chk("R8 still first addr", o_addr, 32'd1);
  endtask

  task automatic t_evict();
    logic [31:0] fa = ref_crc(line_a);
    logic [511:0] c;
    for (int k = 1; k < 100000; k++) begin
      c = {480'h0, 32'(k)};
      if (ref_crc(c)[5:0] == fa[5:0] && ref_crc(c) != fa) break;
    end
    run_line("R10 collide", 32'd4, c);
    chk("R10 no read", o_rds, 0);
    run_line("R10 evicted", 32'd5, line_a);
    chk("R10 evicted nondup", o_dup, 0);
  endtask

  task automatic t_mismatch();
    int l0, l63, lf;
    mem[5][7:0] = mem[5][7:0] ^ 8'hFF;
    run_line("R6 byte0", 32'd6, line_a);
    chk("R6 byte0 nondup", o_dup, 0);
    l0 = o_lat;
    run_line("R6 replaced", 32'd7, line_a);
    chk("R6 new addr", o_addr, 32'd6);
    mem[6][511:504] = mem[6][511:504] ^ 8'h01;
    run_line("R7 byte63", 32'd8, line_a);
    chk("R7 byte63 nondup", o_dup, 0);
    l63 = o_lat;
    chk("R7 latency delta", l63 - l0, 63);
    run_line("R7 full", 32'd9, line_a);
    lf = o_lat;
    chk("R7 full latency", lf, l63);
  endtask

  task automatic t_patterns();
    run_line("R2 zero", 32'd10, 512'h0);
    run_line("R2 ones", 32'd11, {512{1'b1}});
    run_line("R2 ramp", 32'd12, {8{64'h0706050403020100}});
    run_line("R5 zero again", 32'd13, 512'h0);
    chk("R5 zero addr", o_addr, 32'd10);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      m_vld[i] = 1'b0; m_tag[i] = '0; m_adr[i] = '0;
    end
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fresh();
    t_dup();
    t_evict();
    t_mismatch();
    t_patterns();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule